// File: doc/BRIEF.md
# Branch Trace Buffer with Repeat Compression

The block records program-flow discontinuities reported by a processor core. Each accepted event stores a 32-bit source address and a 32-bit destination address as one entry in a 16-deep circular store. A capture port carries one event per cycle, with two attributes: a flag saying the branch came from a zero-overhead hardware loop, and the interrupt priority level the core is running at. Filtering rules decide which events are kept.

Software drives the block through a 32-bit register port. A control register turns capture on and selects the options. A status register reports how many entries are held. A data register drains entries newest-first, taking two reads per entry. Repeated branches can be folded into existing entries rather than stored again. When the store is full, the block either drops the oldest entry or discards the event and pulses an exception output.

Top module: `branch_trace_buf`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, a data read returns 0 and the exception output is low.
- R2: Control bit 0 (power) and bit 1 (enable) must both be 1 for any event to be stored. With either bit clear, a capture leaves the count unchanged.
- R3: An event with the hardware-loop flag set is never stored.
- R4: An event at priority level 1 (the reset level) is always dropped. When control bit 2 (overflow-exception mode) is set, events at levels 0 to 3 are also dropped. Level 2 is accepted while bit 2 is clear.
- R5: When the store holds 16 entries, bit 2 is set and an otherwise accepted event arrives, the event is discarded and the exception output is high for exactly the next cycle. The store is unchanged.
- R6: When the store holds 16 entries and bit 2 is clear, a new event replaces the oldest entry and the count stays at 16.
- R7: With control bit 3 set and at least one entry held, an event whose source and destination match the newest entry in bits 31..1 is not stored. Instead, bit 0 of that entry's destination becomes 1.
- R8: With control bit 4 set and at least two entries held, an event that matches the second-newest entry in bits 31..1 is not stored. Instead, bit 0 of that entry's source becomes 1. The bit-3 check takes precedence when both would match.
- R9: The data register is at offset 0x100. Its reads alternate: the first returns the newest entry's destination, and the second returns that entry's source and removes the entry. A read while empty returns 0 and does not advance the alternation.
- R10: The control register is at offset 0x000 and all 32 bits read back as written. The status register is at offset 0x004 and reads the entry count. Writes to the status or data register have no effect. An access whose word flag is low, or to any other offset, has no effect and reads 0.
- R11: When a capture and a data read happen in the same cycle, the capture is applied first and the read sees the store as updated by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_valid | input | 1 | A branch event is presented this cycle |
| cap_src | input | 32 | Branch source address |
| cap_dst | input | 32 | Branch destination address |
| cap_loop | input | 1 | Event comes from a hardware loop |
| cap_lvl | input | LVL_W | Current interrupt priority level |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | Access is a full 32-bit word |
| bus_addr | input | BUS_AW | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| ovf_exc | output | 1 | One-cycle overflow exception pulse |

## Verification
Two corner cases are hard to reach. The first is an event that matches both the newest and the second-newest entry, which is the only way to see which compression check wins. The bench reaches it by storing a duplicate while only two-level compression is on, then turning one-level compression on and repeating the event. The second is a full store in exception mode: the bench fills all 16 slots with overwrite mode active, then sets the exception bit and presents accepted and filtered events. A reference model in the bench follows every capture and read, including reads that share a cycle with a capture.

// File: rtl/tbuf_pkg.sv
// Package: shared constants and types for the branch trace buffer.
// Assumes a 32-bit register port and 32-bit addresses.
package tbuf_pkg;
    localparam int DW = 32;

    // control register bit positions
    localparam int CTL_PWR  = 0;
    localparam int CTL_EN   = 1;
    localparam int CTL_OVX  = 2;
    localparam int CTL_CMP1 = 3;
    localparam int CTL_CMP2 = 4;

    // register offsets
    localparam logic [11:0] OFS_CTRL = 12'h000;
    localparam logic [11:0] OFS_STAT = 12'h004;
    localparam logic [11:0] OFS_DATA = 12'h100;

    // decoded operating mode
    typedef struct packed {
        logic cmp2;
        logic cmp1;
        logic ovx;
        logic en;
        logic pwr;
    } tb_mode_t;
endpackage

// File: rtl/tbuf_gate.sv
// Module: tbuf_gate
// Decides whether a presented branch event may enter the store.
// Assumes the level input is the core's current priority level, and that
// levels numerically at or below EXC_LVL are emulation/exception levels.
module tbuf_gate
    import tbuf_pkg::*;
#(
    parameter int LVL_W   = 4,
    parameter int RST_LVL = 1,
    parameter int EXC_LVL = 3
) (
    input  logic             cap_valid,
    input  logic             cap_loop,
    input  logic [LVL_W-1:0] cap_lvl,
    input  tb_mode_t         mode,
    output logic             take
);
    localparam logic [LVL_W-1:0] RST_L = LVL_W'(RST_LVL);
    localparam logic [LVL_W-1:0] EXC_L = LVL_W'(EXC_LVL);

    logic armed;
    logic lvl_ok;

    // capture is armed only when powered and enabled
    always_comb armed = mode.pwr && mode.en;

    // level filter: reset level never, low levels not in exception mode
    always_comb lvl_ok = (cap_lvl != RST_L) && !((cap_lvl <= EXC_L) && mode.ovx);

    // final acceptance
    always_comb take = cap_valid && armed && !cap_loop && lvl_ok;
endmodule

// File: rtl/tbuf_store.sv
// Module: tbuf_store
// Circular store of source/destination pairs with repeat compression,
// overwrite-or-exception on full, and a newest-first two-read drain.
// Assumes DEPTH is a power of two. The read word is combinational and
// reflects the store after any capture in the same cycle.
module tbuf_store
    import tbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [DW-1:0]    cap_src,
    input  logic [DW-1:0]    cap_dst,
    input  tb_mode_t         mode,
    input  logic             pop,
    output logic [DW-1:0]    rd_word,
    output logic [CNT_W-1:0] fill,
    output logic [CNT_W-1:0] fill_view,
    output logic             ovf_exc
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DW-1:0]    src_mem [DEPTH];
    logic [DW-1:0]    dst_mem [DEPTH];
    logic [PTR_W-1:0] wptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             mid_q;
    logic             exc_q;

    logic [PTR_W-1:0] idx_last, idx_prev;
    logic             full, hit1, hit2;
    logic             exc_set, mark1, mark2, put;
    logic [PTR_W-1:0] wptr_cap, wptr_nxt;
    logic [CNT_W-1:0] cnt_cap, cnt_nxt;
    logic [DW-1:0]    new_src, new_dst;
    logic             have, drop;

    // slot indices of the newest and second-newest entries
    always_comb begin
        idx_last = wptr_q - PTR_W'(1);
        idx_prev = wptr_q - PTR_W'(2);
    end

    // match detection for both compression levels (bit 0 ignored)
    always_comb begin
        full = (cnt_q == FULL_CNT);
        hit1 = mode.cmp1 && (cnt_q != '0)
            && (cap_src[DW-1:1] == src_mem[idx_last][DW-1:1])
            && (cap_dst[DW-1:1] == dst_mem[idx_last][DW-1:1]);
        hit2 = mode.cmp2 && (cnt_q >= CNT_W'(2))
            && (cap_src[DW-1:1] == src_mem[idx_prev][DW-1:1])
            && (cap_dst[DW-1:1] == dst_mem[idx_prev][DW-1:1]);
    end

    // capture decision: exception, compress into an entry, or store
    always_comb begin
        exc_set = 1'b0;
        mark1   = 1'b0;
        mark2   = 1'b0;
        put     = 1'b0;
        if (take) begin
            if (full && mode.ovx) exc_set = 1'b1;
            else if (hit1)        mark1   = 1'b1;
            else if (hit2)        mark2   = 1'b1;
            else                  put     = 1'b1;
        end
    end

    // pointer and count after the capture step
    always_comb begin
        wptr_cap = put ? wptr_q + PTR_W'(1) : wptr_q;
        cnt_cap  = (put && !full) ? cnt_q + CNT_W'(1) : cnt_q;
    end

    // newest entry as seen after the capture step
    always_comb begin
        if (put) begin
            new_src = cap_src;
            new_dst = cap_dst;
        end else begin
            new_src = src_mem[idx_last];
            new_dst = dst_mem[idx_last] | DW'(mark1);
        end
    end

    // drain path: destination first, then source with removal
    always_comb begin
        have     = (cnt_cap != '0);
        drop     = pop && have && mid_q;
        rd_word  = (pop && have) ? (mid_q ? new_src : new_dst) : '0;
        wptr_nxt = drop ? wptr_cap - PTR_W'(1) : wptr_cap;
        cnt_nxt  = drop ? cnt_cap - CNT_W'(1) : cnt_cap;
    end

    // entry storage and in-place compression marks
    always_ff @(posedge clk) begin
        if (put) begin
            src_mem[wptr_q] <= cap_src;
            dst_mem[wptr_q] <= cap_dst;
        end
        if (mark1) dst_mem[idx_last][0] <= 1'b1;
        if (mark2) src_mem[idx_prev][0] <= 1'b1;
    end

    // pointer, count, read phase and exception pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            cnt_q  <= '0;
            mid_q  <= 1'b0;
            exc_q  <= 1'b0;
        end else begin
            wptr_q <= wptr_nxt;
            cnt_q  <= cnt_nxt;
            mid_q  <= (pop && have) ? !mid_q : mid_q;
            exc_q  <= exc_set;
        end
    end

    assign fill      = cnt_q;
    assign fill_view = cnt_cap;
    assign ovf_exc   = exc_q;

    AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= FULL_CNT); // R6
    AST_EXC_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        exc_q |-> ($past(cnt_q) == FULL_CNT) && $past(mode.ovx)); // R5
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == FULL_CNT && !pop) |=> (cnt_q == FULL_CNT)); // R6
    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))
        || (cnt_q == $past(cnt_q) - CNT_W'(1))); // R9
endmodule

// File: rtl/branch_trace_buf.sv
// Module: branch_trace_buf
// Top of the branch trace buffer: register port decode, control register,
// capture filter and entry store. Assumes one register access per cycle,
// read data used in the same cycle, and word accesses flagged by bus_word.
module branch_trace_buf
    import tbuf_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int LVL_W   = 4,
    parameter int RST_LVL = 1,
    parameter int EXC_LVL = 3,
    parameter int BUS_AW  = 12,
    localparam int CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_valid,
    input  logic [DW-1:0]     cap_src,
    input  logic [DW-1:0]     cap_dst,
    input  logic              cap_loop,
    input  logic [LVL_W-1:0]  cap_lvl,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_word,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              ovf_exc
);
    localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(OFS_CTRL);
    localparam logic [BUS_AW-1:0] A_STAT = BUS_AW'(OFS_STAT);
    localparam logic [BUS_AW-1:0] A_DATA = BUS_AW'(OFS_DATA);

    logic [DW-1:0]    ctrl_q;
    tb_mode_t         mode;
    logic             acc, ctrl_wr, pop, take;
    logic [DW-1:0]    rd_word;
    logic [CNT_W-1:0] fill, fill_view;

    // word-sized accesses only; decode control write and data pop
    always_comb begin
        acc     = bus_en && bus_word;
        ctrl_wr = acc && bus_we && (bus_addr == A_CTRL);
        pop     = acc && !bus_we && (bus_addr == A_DATA);
    end

    // control register, all bits kept as written
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= bus_wdata;
    end

    // operating mode fields pulled from the control register
    always_comb begin
        mode.pwr  = ctrl_q[CTL_PWR];
        mode.en   = ctrl_q[CTL_EN];
        mode.ovx  = ctrl_q[CTL_OVX];
        mode.cmp1 = ctrl_q[CTL_CMP1];
        mode.cmp2 = ctrl_q[CTL_CMP2];
    end

    tbuf_gate #(
        .LVL_W  (LVL_W),
        .RST_LVL(RST_LVL),
        .EXC_LVL(EXC_LVL)
    ) u_gate (
        .cap_valid(cap_valid),
        .cap_loop (cap_loop),
        .cap_lvl  (cap_lvl),
        .mode     (mode),
        .take     (take)
    );

    tbuf_store #(
        .DEPTH(DEPTH)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .cap_src  (cap_src),
        .cap_dst  (cap_dst),
        .mode     (mode),
        .pop      (pop),
        .rd_word  (rd_word),
        .fill     (fill),
        .fill_view(fill_view),
        .ovf_exc  (ovf_exc)
    );

    // read data mux; unmapped offsets and writes return zero
    always_comb begin
        bus_rdata = '0;
        if (acc && !bus_we) begin
            if (bus_addr == A_CTRL)      bus_rdata = ctrl_q;
            else if (bus_addr == A_STAT) bus_rdata = DW'(fill_view);
            else if (bus_addr == A_DATA) bus_rdata = rd_word;
        end
    end

    AST_LOOP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_loop) |-> !take); // R3
    AST_POWER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_q[CTL_PWR] && ctrl_q[CTL_EN]) |-> !take); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !pop) |=> $stable(fill)); // R2
    AST_NO_RESET_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_lvl == LVL_W'(RST_LVL)) |-> !take); // R4
endmodule

// File: tb/sim_branch_trace_buf.sv
// Scoreboard bench: the driver updates a reference model and queues the
// expected read data; a monitor compares at the falling edge.
module sim_branch_trace_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_valid = 1'b0;
    logic [31:0] cap_src = '0;
    logic [31:0] cap_dst = '0;
    logic        cap_loop = 1'b0;
    logic [3:0]  cap_lvl = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_word = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ovf_exc;

    branch_trace_buf u0 (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_src(cap_src),
        .cap_dst(cap_dst), .cap_loop(cap_loop), .cap_lvl(cap_lvl),
        .bus_en(bus_en), .bus_we(bus_we), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ovf_exc(ovf_exc)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model
    logic [31:0] msrc[$];
    logic [31:0] mdst[$];
    bit          mmid = 0;
    logic [31:0] mctrl = '0;

    // scoreboard
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          rd_active = 0;
    bit          exp_exc_now = 0;
    bit          pend_exc = 0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    task automatic model_cap(input logic [31:0] s, input logic [31:0] d, input bit lp,
                             input logic [3:0] lv, output bit ex);
        int n;
        ex = 0;
        n = msrc.size();
        if (!(mctrl[0] && mctrl[1])) return;
        if (lp) return;
        if (lv == 4'd1) return;
        if (lv <= 4'd3 && mctrl[2]) return;
        if (n == 16 && mctrl[2]) begin ex = 1; return; end
        if (mctrl[3] && n >= 1 && s[31:1] == msrc[n-1][31:1] && d[31:1] == mdst[n-1][31:1]) begin
            mdst[n-1] = mdst[n-1] | 32'h1;
            return;
        end
        if (mctrl[4] && n >= 2 && s[31:1] == msrc[n-2][31:1] && d[31:1] == mdst[n-2][31:1]) begin
            msrc[n-2] = msrc[n-2] | 32'h1;
            return;
        end
        if (n == 16) begin
            void'(msrc.pop_front());
            void'(mdst.pop_front());
        end
        msrc.push_back(s);
        mdst.push_back(d);
    endtask

    task automatic model_read(input logic [11:0] a, input bit wd, output logic [31:0] v);
        int n;
        v = '0;
        n = msrc.size();
        if (!wd) return;
        if (a == 12'h000) v = mctrl;
        else if (a == 12'h004) v = 32'(n);
        else if (a == 12'h100 && n != 0) begin
            if (mmid) begin
                v = msrc[n-1];
                void'(msrc.pop_back());
                void'(mdst.pop_back());
            end else begin
                v = mdst[n-1];
            end
            mmid = !mmid;
        end
    endtask

    // one clock cycle of stimulus with model update
    task automatic step(input bit cv, input logic [31:0] s, input logic [31:0] d,
                        input bit lp, input logic [3:0] lv, input bit en, input bit we,
                        input bit wd, input logic [11:0] a, input logic [31:0] wv,
                        input string tag);
        bit ex;
        logic [31:0] e;
        @(posedge clk);
        #2;
        cap_valid = cv; cap_src = s; cap_dst = d; cap_loop = lp; cap_lvl = lv;
        bus_en = en; bus_we = we; bus_word = wd; bus_addr = a; bus_wdata = wv;
        ex = 0;
        if (cv) model_cap(s, d, lp, lv, ex);
        rd_active = 0;
        if (en) begin
            if (we) begin
                if (wd && a == 12'h000) mctrl = wv;
            end else begin
                model_read(a, wd, e);
                exp_q.push_back(e);
                tag_q.push_back(tag);
                rd_active = 1;
            end
        end
        exp_exc_now = pend_exc;
        pend_exc = ex;
    endtask

    task automatic idle;
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask
    task automatic cap(input logic [31:0] s, input logic [31:0] d, input bit lp, input logic [3:0] lv);
        step(1, s, d, lp, lv, 0, 0, 0, 0, 0, "");
    endtask
    task automatic wr(input logic [11:0] a, input logic [31:0] v, input bit wd);
        step(0, 0, 0, 0, 0, 1, 1, wd, a, v, "");
    endtask
    task automatic rd(input logic [11:0] a, input bit wd, input string tag);
        step(0, 0, 0, 0, 0, 1, 0, wd, a, 0, tag);
    endtask
    task automatic cap_rd(input logic [31:0] s, input logic [31:0] d, input string tag);
        step(1, s, d, 0, 4'd6, 1, 0, 1, 12'h100, 0, tag);
    endtask
    task automatic drain(input string tag);
        while (msrc.size() != 0) rd(12'h100, 1, tag);
    endtask

    // monitor: compare read data and exception pulse
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rd_active) check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            check({31'b0, ovf_exc}, {31'b0, exp_exc_now}, "R5 exception pulse");
        end
    end

    // watchdog
    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        rd(12'h000, 1, "R1 ctrl after reset");
        rd(12'h004, 1, "R1 status after reset");
        rd(12'h100, 1, "R1 data empty after reset");

        // R2 power and enable gating
        wr(12'h000, 32'h1, 1);
        cap(32'h100, 32'h200, 0, 4'd6);
        rd(12'h004, 1, "R2 power only");
        wr(12'h000, 32'h2, 1);
        cap(32'h100, 32'h200, 0, 4'd6);
        rd(12'h004, 1, "R2 enable only");

        // R10 register behaviour
        wr(12'h000, 32'hABCD_0003, 1);
        rd(12'h000, 1, "R10 ctrl readback");
        wr(12'h004, 32'h5, 1);
        wr(12'h100, 32'h7, 1);
        rd(12'h004, 1, "R10 status write ignored");
        wr(12'h000, 32'h0, 0);
        rd(12'h000, 1, "R10 narrow write ignored");
        rd(12'h000, 0, "R10 narrow read zero");
        rd(12'h008, 1, "R10 unmapped read zero");

        // R3 and R4 filtering
        cap(32'h1000, 32'h2000, 1, 4'd6);
        rd(12'h004, 1, "R3 loop event dropped");
        cap(32'h1000, 32'h2000, 0, 4'd1);
        rd(12'h004, 1, "R4 reset level dropped");
        cap(32'h1100, 32'h2100, 0, 4'd2);
        rd(12'h004, 1, "R4 level 2 accepted without ovx");
        wr(12'h000, 32'h7, 1);
        cap(32'h1200, 32'h2200, 0, 4'd3);
        cap(32'h1300, 32'h2300, 0, 4'd0);
        rd(12'h004, 1, "R4 low levels dropped with ovx");
        cap(32'h1400, 32'h2400, 0, 4'd4);
        rd(12'h004, 1, "R4 level 4 accepted");

        // R9 newest-first drain and empty read
        drain("R9 drain order");
        rd(12'h100, 1, "R9 empty read zero");
        rd(12'h004, 1, "R9 empty status");

        // R7 and R8 compression
        wr(12'h000, 32'h1B, 1);
        cap(32'hA000, 32'hB000, 0, 4'd6);
        cap(32'hA000, 32'hB000, 0, 4'd6);
        cap(32'hA001, 32'hB000, 0, 4'd6);
        rd(12'h004, 1, "R7 repeats folded");
        cap(32'hC000, 32'hD000, 0, 4'd6);
        cap(32'hA000, 32'hB000, 0, 4'd6);
        cap(32'hC000, 32'hD000, 0, 4'd6);
        rd(12'h004, 1, "R8 two-level fold");
        wr(12'h000, 32'h13, 1);
        cap(32'hE000, 32'hF000, 0, 4'd6);
        cap(32'hE000, 32'hF000, 0, 4'd6);
        wr(12'h000, 32'h1B, 1);
        cap(32'hE000, 32'hF000, 0, 4'd6);
        rd(12'h004, 1, "R8 precedence count");
        drain("R7 R8 marked entries");

        // R6 overwrite when full
        wr(12'h000, 32'h3, 1);
        for (int i = 0; i < 18; i++) cap(32'h4000_0000 + 32'(i * 8), 32'h5000_0000 + 32'(i * 8), 0, 4'd6);
        rd(12'h004, 1, "R6 count stays 16");
        drain("R6 oldest overwritten");

        // R5 exception when full
        for (int i = 0; i < 16; i++) cap(32'h6000_0000 + 32'(i * 8), 32'h7000_0000 + 32'(i * 8), 0, 4'd6);
        wr(12'h000, 32'h7, 1);
        cap(32'h9000_0000, 32'h9100_0000, 0, 4'd6);
        idle();
        idle();
        cap(32'h9200_0000, 32'h9300_0000, 0, 4'd2);
        idle();
        rd(12'h004, 1, "R5 store unchanged");
        rd(12'h100, 1, "R5 newest kept");
        rd(12'h100, 1, "R5 newest kept src");
        wr(12'h000, 32'h3, 1);
        drain("R5 remaining drain");

        // R11 capture and read in the same cycle
        cap_rd(32'h8000_0010, 32'h8100_0010, "R11 read sees capture");
        cap_rd(32'h8000_0020, 32'h8100_0020, "R11 second read sees new entry");
        rd(12'h004, 1, "R11 count");
        drain("R11 drain");
        idle();
        idle();
        @(negedge clk);
        #1;
        report();
        $finish;
    end
endmodule